// File: doc/BRIEF.md
# Fractional-Divider UART Baud Generator

This block produces the two timing strobes that an asynchronous serial transmitter and receiver need. The first is an oversampling strobe. The second is a strobe at the bit rate. Both are single-cycle enables in the module clock domain, and no derived clock leaves the block.

The input stage turns the module clock into a stream of enable pulses. It has three settings: a fixed divide-by-2, a fixed divide-by-3, or a programmable n/512 rate divider. The rate divider lets the bit rate be trimmed finely, well beyond what the integer settings allow. A down-counting reload timer divides this pulse stream by (reload+1) to give the sample strobe. A divide-by-16 stage turns the sample strobe into the bit-rate strobe.

Software, or a register block outside this unit, sets the mode bits, the fraction and the reload value. It then raises the run input.

Top module: `frac_baud_gen`

## Requirements
- R1: With the fraction enable at 0 and the divide select at 0, the input stage divides by 2. The sample strobe then repeats every 2·(reload+1) module clocks, which gives a bit rate of fMOD/(32·(reload+1)).
- R2: With the fraction enable at 0 and the divide select at 1, the input stage divides by 3. The sample strobe then repeats every 3·(reload+1) clocks, which gives a bit rate of fMOD/(48·(reload+1)).
- R3: With the fraction enable at 1, the input stage emits n pulses per 512 clocks on average, where n is the 9-bit fraction value. The bit rate is (n/512)·fMOD/(16·(reload+1)), and the divide select has no effect. Over a window, the counted bit strobes match the closed form within 1.25 ticks.
- R4: A fraction value of 0 means a ratio of 1. The input stage then pulses every clock, so the sample strobe repeats every reload+1 clocks. With reload 0, the bit rate reaches fMOD/16.
- R5: The bit-rate strobe fires once per 16 sample strobes, one clock after the 16th sample strobe. It is never high on two clocks in a row.
- R6: The 13-bit reload value is taken only when the timer underflows. A new value written in the middle of a count leaves that count unchanged, and the next period uses the new value.
- R7: While run is low, the input stage, the timer and the divide-by-16 counter are all held cleared, and neither strobe fires. After run rises again, the first bit strobe comes a full 16 sample periods later.
- R8: When run rises, the timer loads the reload value at once. The first sample strobe appears at the (reload+2)-th rising edge, counting the edge that first samples run high, when the fraction is 0.
- R9: During reset and after reset, both strobes are low until run is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Enables the generator; low clears all counters |
| frac_en | input | 1 | 1 selects the fractional input stage |
| div3_sel | input | 1 | With frac_en low: 0 selects divide-by-2, 1 selects divide-by-3 |
| frac_val | input | 9 | Fraction n; the input stage rate is n/512 of the clock, 0 means full rate |
| reload_val | input | 13 | Timer reload; the timer divides by reload_val+1 |
| sample_tick | output | 1 | Oversampling strobe, one clock wide |
| baud_tick | output | 1 | Bit-rate strobe, one clock wide |

## Verification
The bench builds the block with its default widths: a 9-bit fraction, a 13-bit reload and an oversampling factor of 16. This makes the full fraction range and the realistic trimming settings reachable, such as n=151 with reload 23, which gives about 19201 baud from 25 MHz. Reload values are kept small in the long-window rate counts, so that each window holds enough bit strobes for a tight tolerance. Exact-cycle checks then cover the gap after run rises, the reload takeover point and the clearing of the divide-by-16 stage.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  typedef enum logic [1:0] {
    PRE_DIV2 = 2'd0,
    PRE_DIV3 = 2'd1,
    PRE_FRAC = 2'd2
  } pre_mode_e;

  // The fraction enable wins: the divide select only matters in fixed mode.
  function automatic pre_mode_e pick_mode(input logic frac_en, input logic div3_sel);
    if (frac_en) return PRE_FRAC;
    return div3_sel ? PRE_DIV3 : PRE_DIV2;
  endfunction

  // Last count of the fixed prescaler before it wraps.
  function automatic logic [1:0] fixed_limit(input pre_mode_e mode);
    return (mode == PRE_DIV3) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/bg_prescaler.sv
module bg_prescaler
  import frac_baud_pkg::*;
#(
  parameter int FRAC_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              frac_en,
  input  logic              div3_sel,
  input  logic [FRAC_W-1:0] frac_val,
  output logic              pre_tick
);

  localparam int SUM_W = FRAC_W + 1;

  // Phase accumulator step: the top bit of the result is the carry out.
  function automatic logic [SUM_W-1:0] acc_step(input logic [FRAC_W-1:0] a,
                                                 input logic [FRAC_W-1:0] n);
    return {1'b0, a} + {1'b0, n};
  endfunction

  pre_mode_e         mode;
  logic [1:0]        fix_cnt;
  logic [1:0]        fix_lim;
  logic              fix_wrap;
  logic [FRAC_W-1:0] acc;
  logic [SUM_W-1:0]  acc_sum;
  logic              frac_pulse;
  logic              next_tick;

  assign mode       = pick_mode(frac_en, div3_sel);
  assign fix_lim    = fixed_limit(mode);
  assign fix_wrap   = (fix_cnt >= fix_lim);
  assign acc_sum    = acc_step(acc, frac_val);
  assign frac_pulse = acc_sum[SUM_W-1] | (frac_val == '0);
  assign next_tick  = (mode == PRE_FRAC) ? frac_pulse : fix_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_cnt  <= '0;
      acc      <= '0;
      pre_tick <= 1'b0;
    end else if (!run) begin
      fix_cnt  <= '0;
      acc      <= '0;
      pre_tick <= 1'b0;
    end else begin
      fix_cnt  <= fix_wrap ? 2'd0 : fix_cnt + 2'd1;
      acc      <= acc_sum[FRAC_W-1:0];
      pre_tick <= next_tick;
    end
  end

  // R4: a zero fraction keeps the enable high on every clock.
  assert_frac_zero_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run) && $past(mode == PRE_FRAC) && $past(frac_val == '0))
      |-> pre_tick);

  // R1/R2: the fixed settings never pulse on two clocks in a row.
  assert_fixed_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run) && $past(mode != PRE_FRAC) && $past(pre_tick))
      |-> !pre_tick);

endmodule

// File: rtl/bg_reload_timer.sv
module bg_reload_timer #(
  parameter int RELOAD_W = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                pre_tick,
  input  logic [RELOAD_W-1:0] reload_val,
  output logic                sample_tick
);

  logic [RELOAD_W-1:0] cnt;
  logic [RELOAD_W-1:0] cur_reload;
  logic                underflow;

  assign underflow = pre_tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      cur_reload  <= '0;
      sample_tick <= 1'b0;
    end else if (!run) begin
      cnt         <= reload_val;
      cur_reload  <= reload_val;
      sample_tick <= 1'b0;
    end else if (underflow) begin
      cnt         <= reload_val;
      cur_reload  <= reload_val;
      sample_tick <= 1'b1;
    end else begin
      if (pre_tick) cnt <= cnt - 1'b1;
      sample_tick <= 1'b0;
    end
  end

  // R3: every sample strobe is caused by an input stage pulse.
  assert_tick_from_prescale_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> $past(pre_tick));

  // R6: the period in use only changes at an underflow.
  assert_reload_at_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run) && run && !$past(underflow)) |-> $stable(cur_reload));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cur_reload);

endmodule

// File: rtl/bg_oversample_div.sv
module bg_oversample_div #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sample_tick,
  output logic baud_tick
);

  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = sample_tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      baud_tick <= 1'b0;
    end else if (!run) begin
      cnt       <= '0;
      baud_tick <= 1'b0;
    end else begin
      if (sample_tick) cnt <= wrap ? '0 : cnt + 1'b1;
      baud_tick <= wrap;
    end
  end

  // R5: the bit strobe follows a sample strobe and is one clock wide.
  assert_baud_follows_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> $past(sample_tick));

  assert_baud_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int FRAC_W     = 9,
  parameter int RELOAD_W   = 13,
  parameter int OVERSAMPLE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                frac_en,
  input  logic                div3_sel,
  input  logic [FRAC_W-1:0]   frac_val,
  input  logic [RELOAD_W-1:0] reload_val,
  output logic                sample_tick,
  output logic                baud_tick
);

  logic pre_tick;

  bg_prescaler #(.FRAC_W(FRAC_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .frac_en  (frac_en),
    .div3_sel (div3_sel),
    .frac_val (frac_val),
    .pre_tick (pre_tick)
  );

  bg_reload_timer #(.RELOAD_W(RELOAD_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .pre_tick    (pre_tick),
    .reload_val  (reload_val),
    .sample_tick (sample_tick)
  );

  bg_oversample_div #(.OVERSAMPLE(OVERSAMPLE)) u_os (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .sample_tick (sample_tick),
    .baud_tick   (baud_tick)
  );

  // R7: a low run input silences every strobe on the next clock.
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sample_tick && !baud_tick && !pre_tick));

  // R9: nothing fires straight out of reset.
  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!sample_tick && !baud_tick));

endmodule

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 12000;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        frac_en = 1'b0;
  logic        div3_sel = 1'b0;
  logic [8:0]  frac_val = '0;
  logic [12:0] reload_val = '0;
  logic        sample_tick;
  logic        baud_tick;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  frac_baud_gen uut (
    .clk(clk), .rst_n(rst_n), .run(run), .frac_en(frac_en), .div3_sel(div3_sel),
    .frac_val(frac_val), .reload_val(reload_val),
    .sample_tick(sample_tick), .baud_tick(baud_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Closed-form bit strobes per module clock.
  function automatic real bits_per_clock(input bit fe, input bit sel, input int n, input int r);
    real pre;
    if (fe) pre = (n == 0) ? 1.0 : real'(n) / 512.0;
    else    pre = sel ? 1.0 / 3.0 : 1.0 / 2.0;
    return pre / (16.0 * real'(r + 1));
  endfunction

  task automatic check_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic configure(input bit fe, input bit sel, input int n, input int r);
    @(negedge clk);
    run = 1'b0; frac_en = fe; div3_sel = sel; frac_val = 9'(n); reload_val = 13'(r);
    @(negedge clk);
    @(negedge clk);
  endtask

  // Rising edges until the next sample strobe is seen.
  task automatic sample_gap(output int gap);
    gap = 0;
    do begin
      @(posedge clk); gap++; @(negedge clk);
    end while (!sample_tick && gap < 5000);
  endtask

  task automatic baud_gap(output int gap);
    gap = 0;
    do begin
      @(posedge clk); gap++; @(negedge clk);
    end while (!baud_tick && gap < 5000);
  endtask

  task automatic rate_check(input string req, input bit fe, input bit sel, input int n, input int r);
    int  cnt;
    real expv, diff;
    configure(fe, sel, n, r);
    run = 1'b1;
    repeat (40) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (baud_tick) cnt++;
    end
    expv = real'(WIN) * bits_per_clock(fe, sel, n, r);
    diff = real'(cnt) - expv;
    checks++;
    if (diff > 1.25 || diff < -1.25) begin
      failures++;
      $display("FAIL %s rate fe=%0d sel=%0d n=%0d r=%0d: actual=%0d expected=%f",
               req, fe, sel, n, r, cnt, expv);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int g;
    int quiet;
    void'($urandom(32'd20240611));

    // R9: reset state and idle after reset
    repeat (3) @(negedge clk);
    check_int("R9", "sample_tick in reset", int'(sample_tick), 0);
    check_int("R9", "baud_tick in reset", int'(baud_tick), 0);
    rst_n = 1'b1;
    quiet = 0;
    repeat (20) begin @(negedge clk); quiet += int'(sample_tick) + int'(baud_tick); end
    check_int("R9", "strobes after reset, run low", quiet, 0);

    // R8 and R4: run rise with zero fraction, reload 4
    configure(1'b1, 1'b0, 0, 4);
    run = 1'b1;
    sample_gap(g);  check_int("R8", "first sample strobe edge", g, 6);
    sample_gap(g);  check_int("R4", "sample period at full rate", g, 5);

    // R6: reload change mid-count
    configure(1'b1, 1'b0, 0, 9);
    run = 1'b1;
    sample_gap(g);  check_int("R8", "first strobe, reload 9", g, 11);
    reload_val = 13'd3;
    sample_gap(g);  check_int("R6", "period after mid-count write", g, 10);
    sample_gap(g);  check_int("R6", "period with new reload", g, 4);

    // R1 / R2: exact fixed periods
    configure(1'b0, 1'b0, 0, 2);
    run = 1'b1;
    sample_gap(g);
    sample_gap(g);  check_int("R1", "divide-by-2 sample period", g, 6);
    configure(1'b0, 1'b1, 0, 2);
    run = 1'b1;
    sample_gap(g);
    sample_gap(g);  check_int("R2", "divide-by-3 sample period", g, 9);

    // R5: bit strobe every 16 sample strobes
    configure(1'b1, 1'b0, 0, 1);
    run = 1'b1;
    baud_gap(g);
    baud_gap(g);    check_int("R5", "bit strobe period", g, 32);

    // R7: stop clears everything, restart counts a full 16 samples
    configure(1'b1, 1'b0, 0, 0);
    run = 1'b1;
    repeat (7) @(negedge clk);
    run = 1'b0;
    quiet = 0;
    repeat (100) begin @(negedge clk); quiet += int'(sample_tick) + int'(baud_tick); end
    check_int("R7", "strobes while stopped", quiet, 0);
    run = 1'b1;
    baud_gap(g);    check_int("R7", "first bit strobe after restart", g, 18);

    // Rate windows: directed corners
    rate_check("R1", 1'b0, 1'b0, 0, 0);
    rate_check("R2", 1'b0, 1'b1, 0, 2);
    rate_check("R4", 1'b1, 1'b0, 0, 0);
    rate_check("R3", 1'b1, 1'b1, 151, 23);
    rate_check("R3", 1'b1, 1'b0, 511, 1);

    // Rate windows: random fractional settings, select bit random (ignored)
    for (int k = 0; k < 4; k++) begin
      int n = 1 + int'($urandom % 511);
      int r = int'($urandom % 8);
      bit s = 1'($urandom % 2);
      rate_check("R3", 1'b1, s, n, r);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule